// File: doc/BRIEF.md
# Linear CCD Line Timing Generator

This block drives a 3000-pixel linear CCD image sensor from a fast system clock. It makes the sensor's pixel clock, the readout-gate pulse that moves a whole line of charge into the shift register, and an optional electronic-shutter pulse. For every element that the sensor shifts out it also raises a sample strobe for an external converter, tagged with the element's position in the line and its class (plain dummy, optical black or effective pixel).

Each pixel period is cut into eight equal phase steps of a programmable number of system clocks. The pixel clock is high for the first four steps. Both readout-gate edges land two steps after a falling pixel-clock edge, which is a quarter period away from the nearest pixel-clock edge. The shutter edges sit a fixed number of system clocks after a rising pixel-clock edge. Every setting is captured when a start request finds the block idle, and settings outside the sensor's limits are clamped. A stop request takes effect only at the end of the line in progress. The gain-select bit goes straight to the sensor.

Top module: `lccdTimingTop`

## Requirements
- R1: The pixel clock period is 8*D system clocks, with the clock high for the first 4*D of them. D is divStep clamped to [DIV_MIN, DIV_MAX] and captured at start.
- R2: One line lasts L pixel periods. L is lineLen raised to 3100 when it is below 3100. The last rising pixel-clock edge of a line comes (L-1)*8*D clocks after its lineStart.
- R3: The readout gate rises 6*D clocks after lineStart and stays high for G pixel periods. G is gateWidth clamped to [6, 20]. Neither of its edges falls while the pixel clock is high.
- R4: Each line gives exactly 3066 sampleValid pulses carrying pixIndex 0, 1, ..., 3065 in order. Element e is sampled (G+1+e)*8*D + S clocks after lineStart.
- R5: The class code (0 dummy, 1 optical black, 2 effective) is 1 for indices 24..53 and 2 for indices 56..3055. It is 0 for the other 36 indices.
- R6: The sample delay S is sampleDelay clamped to at most 8*D-1.
- R7: With shutEn set, the shutter rises SHUT_LEAD clocks after the rising pixel-clock edge of period P. It stays high for SHUT_PERIODS pixel periods. P is shutOffset clamped to [G+11, L-SHUT_PERIODS-11]. The shutter and the readout gate are never high together. With shutEn clear the shutter stays low.
- R8: lineDone is high for exactly one clock per line, (G+3067)*8*D-1 clocks after lineStart. This is the cycle in which a sample of the last element at delay 8*D-1 also fires.
- R9: gainSel equals gainHigh at all times (high selects x4, low selects x1).
- R10: A start pulse in idle begins a line with lineStart coinciding with a rising pixel clock. A stop pulse during a line lets that line finish, after which no further lineStart occurs and pixClk and readGate stay low.
- R11: While reset is held, every output except gainSel is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin continuous line generation (sampled in idle) |
| stop | input | 1 | Request a halt at the next line boundary |
| divStep | input | DIV_W | System clocks per eighth of a pixel period |
| lineLen | input | LEN_W | Pixel periods per line (minimum 3100) |
| gateWidth | input | GATE_W | Readout-gate high time in pixel periods (6..20, 10 typical) |
| shutEn | input | 1 | Enable the electronic shutter pulse |
| shutOffset | input | LEN_W | Pixel period within the line where the shutter opens |
| sampleDelay | input | DLY_W | Clocks from pixel-clock rise to the sample strobe |
| gainHigh | input | 1 | Output gain request, high for x4 |
| pixClk | output | 1 | Sensor pixel clock |
| readGate | output | 1 | Sensor readout-gate pulse |
| shutter | output | 1 | Sensor electronic-shutter pulse |
| gainSel | output | 1 | Sensor gain-select pin |
| sampleValid | output | 1 | Converter sample strobe |
| pixIndex | output | 12 | Element index within the line |
| pixClass | output | 2 | Element class code |
| lineStart | output | 1 | One-clock pulse at the first clock of a line |
| lineDone | output | 1 | One-clock pulse after the last trailing element |

## Verification
The sample strobe for the final trailing element and the line-done pulse can land in the same system clock. This happens when the sample delay sits at its ceiling of one clock short of a pixel period. One table row asks for a delay above that ceiling at D=2, so the clamp pulls it to 15 and the two events coincide. The bench then checks that index 3065 is still counted as a sample and that lineDone appears exactly once, both at the cycle computed from the gate width and pixel period.

// File: rtl/lccdPkg.sv
package lccdPkg;

  // Output elements per line and the class boundaries within it
  localparam int ELEM_COUNT = 3066;
  localparam int ELEM_W     = $clog2(ELEM_COUNT);
  localparam int OB_FIRST   = 24;
  localparam int OB_LAST    = 53;
  localparam int EFF_FIRST  = 56;
  localparam int EFF_LAST   = 3055;

  typedef enum logic [1:0] {
    CLS_DUMMY = 2'd0,
    CLS_BLACK = 2'd1,
    CLS_PIXEL = 2'd2
  } pixClass_e;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic              run;
    logic              clkHigh;
    logic              gateSet;
    logic              gateClr;
    logic              shutSet;
    logic              shutClr;
    logic              sample;
    logic              lineBegin;
    logic              lineEnd;
    logic [ELEM_W-1:0] elem;
  } lccdStrobe_t;

  function automatic pixClass_e classOf(input logic [ELEM_W-1:0] e);
    int v;
    v = int'(e);
    if (v >= OB_FIRST && v <= OB_LAST)        return CLS_BLACK;
    else if (v >= EFF_FIRST && v <= EFF_LAST) return CLS_PIXEL;
    else                                      return CLS_DUMMY;
  endfunction

endpackage

// File: rtl/lccdControl.sv
module lccdControl
  import lccdPkg::*;
#(
  parameter int DIV_W        = 6,
  parameter int DIV_MIN      = 7,
  parameter int DIV_MAX      = 62,
  parameter int LEN_W        = 13,
  parameter int MIN_LINE     = 3100,
  parameter int GATE_W       = 5,
  parameter int GATE_MIN     = 6,
  parameter int GATE_MAX     = 20,
  parameter int SHUT_PERIODS = 5,
  parameter int SHUT_LEAD    = 10,
  parameter int SEP_PERIODS  = 10,
  parameter int DLY_W        = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic [DIV_W-1:0]  divStep,
  input  logic [LEN_W-1:0]  lineLen,
  input  logic [GATE_W-1:0] gateWidth,
  input  logic              shutEn,
  input  logic [LEN_W-1:0]  shutOffset,
  input  logic [DLY_W-1:0]  sampleDelay,
  output lccdStrobe_t       strobe
);

  localparam int CYC_W = $clog2(8 * DIV_MAX);

  // Captured configuration
  logic [CYC_W-1:0]  cycMaxL, halfL, gatePhL, dlyL;
  logic [LEN_W-1:0]  lenL, shOffL;
  logic [GATE_W-1:0] gwL;
  logic              shEnL;

  // Run state
  logic              running, stopPend;
  logic [CYC_W-1:0]  cyc;
  logic [LEN_W-1:0]  period;

  // Clamped request values
  logic [DIV_W-1:0]  divC;
  logic [CYC_W-1:0]  stepC, cycMaxC, dlyC;
  logic [LEN_W-1:0]  lenC, shLo, shHi, shC;
  logic [GATE_W-1:0] gwC;

  always_comb begin
    if (int'(divStep) < DIV_MIN)      divC = DIV_W'(DIV_MIN);
    else if (int'(divStep) > DIV_MAX) divC = DIV_W'(DIV_MAX);
    else                              divC = divStep;
    stepC   = CYC_W'(divC);
    cycMaxC = (stepC << 3) - CYC_W'(1);

    if (int'(lineLen) < MIN_LINE) lenC = LEN_W'(MIN_LINE);
    else                          lenC = lineLen;

    if (int'(gateWidth) < GATE_MIN)      gwC = GATE_W'(GATE_MIN);
    else if (int'(gateWidth) > GATE_MAX) gwC = GATE_W'(GATE_MAX);
    else                                 gwC = gateWidth;

    shLo = LEN_W'(gwC) + LEN_W'(SEP_PERIODS + 1);
    shHi = lenC - LEN_W'(SHUT_PERIODS + SEP_PERIODS + 1);
    if (shutOffset < shLo)      shC = shLo;
    else if (shutOffset > shHi) shC = shHi;
    else                        shC = shutOffset;

    if (int'(sampleDelay) > int'(cycMaxC)) dlyC = cycMaxC;
    else                                   dlyC = CYC_W'(sampleDelay);
  end

  logic lastCyc, lastPeriod;
  assign lastCyc    = (cyc == cycMaxL);
  assign lastPeriod = (period == lenL - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      stopPend <= 1'b0;
      cyc      <= '0;
      period   <= '0;
      cycMaxL  <= '0;
      halfL    <= '0;
      gatePhL  <= '0;
      dlyL     <= '0;
      lenL     <= LEN_W'(MIN_LINE);
      shOffL   <= '0;
      gwL      <= GATE_W'(GATE_MIN);
      shEnL    <= 1'b0;
    end else if (!running) begin
      if (start) begin
        running  <= 1'b1;
        stopPend <= 1'b0;
        cyc      <= '0;
        period   <= '0;
        cycMaxL  <= cycMaxC;
        halfL    <= stepC << 2;
        gatePhL  <= (stepC << 2) + (stepC << 1);
        dlyL     <= dlyC;
        lenL     <= lenC;
        shOffL   <= shC;
        gwL      <= gwC;
        shEnL    <= shutEn;
      end
    end else begin
      stopPend <= stopPend | stop;
      if (lastCyc) begin
        cyc <= '0;
        if (lastPeriod) begin
          period <= '0;
          if (stopPend || stop) running <= 1'b0;
        end else begin
          period <= period + LEN_W'(1);
        end
      end else begin
        cyc <= cyc + CYC_W'(1);
      end
    end
  end

  // Element window follows the readout gate by one period
  logic [LEN_W-1:0] elemFirst, elemLast, elemOff;
  logic             inElem;
  assign elemFirst = LEN_W'(gwL) + LEN_W'(1);
  assign elemLast  = LEN_W'(gwL) + LEN_W'(ELEM_COUNT);
  assign inElem    = (period >= elemFirst) && (period <= elemLast);
  assign elemOff   = period - elemFirst;

  always_comb begin
    strobe = '0;
    if (running) begin
      strobe.run       = 1'b1;
      strobe.clkHigh   = (cyc < halfL);
      strobe.gateSet   = (period == '0) && (cyc == gatePhL);
      strobe.gateClr   = (period == LEN_W'(gwL)) && (cyc == gatePhL);
      strobe.shutSet   = shEnL && (period == shOffL) && (cyc == CYC_W'(SHUT_LEAD));
      strobe.shutClr   = shEnL && (period == shOffL + LEN_W'(SHUT_PERIODS))
                         && (cyc == CYC_W'(SHUT_LEAD));
      strobe.sample    = inElem && (cyc == dlyL);
      strobe.lineBegin = (period == '0) && (cyc == '0);
      strobe.lineEnd   = (period == elemLast) && lastCyc;
      strobe.elem      = ELEM_W'(elemOff);
    end
  end

  // R1
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (cyc <= cycMaxL));

  // R2
  period_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (period < lenL));

  // R10
  stop_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && !(lastCyc && lastPeriod)) |=> running);

endmodule

// File: rtl/lccdDatapath.sv
module lccdDatapath
  import lccdPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lccdStrobe_t       strobe,
  output logic              pixClk,
  output logic              readGate,
  output logic              shutter,
  output logic              sampleValid,
  output logic [ELEM_W-1:0] pixIndex,
  output logic [1:0]        pixClass,
  output logic              lineStart,
  output logic              lineDone
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixClk      <= 1'b0;
      readGate    <= 1'b0;
      shutter     <= 1'b0;
      sampleValid <= 1'b0;
      pixIndex    <= '0;
      pixClass    <= 2'd0;
      lineStart   <= 1'b0;
      lineDone    <= 1'b0;
    end else begin
      pixClk      <= strobe.run && strobe.clkHigh;
      sampleValid <= strobe.sample;
      lineStart   <= strobe.lineBegin;
      lineDone    <= strobe.lineEnd;

      if (!strobe.run)          readGate <= 1'b0;
      else if (strobe.gateSet)  readGate <= 1'b1;
      else if (strobe.gateClr)  readGate <= 1'b0;

      if (!strobe.run)          shutter <= 1'b0;
      else if (strobe.shutSet)  shutter <= 1'b1;
      else if (strobe.shutClr)  shutter <= 1'b0;

      if (strobe.sample) begin
        pixIndex <= strobe.elem;
        pixClass <= 2'(classOf(strobe.elem));
      end
    end
  end

  // R7
  gate_shut_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(readGate && shutter));

  // R3
  gate_rise_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readGate) |-> !pixClk);

  // R3
  gate_fall_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readGate) |-> !pixClk);

  // R10
  line_start_clk_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineStart |-> (pixClk && !$past(pixClk)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> !lineDone);

endmodule

// File: rtl/lccdTimingTop.sv
module lccdTimingTop
  import lccdPkg::*;
#(
  parameter int DIV_W        = 6,
  parameter int DIV_MIN      = 7,
  parameter int DIV_MAX      = 62,
  parameter int LEN_W        = 13,
  parameter int MIN_LINE     = 3100,
  parameter int GATE_W       = 5,
  parameter int GATE_MIN     = 6,
  parameter int GATE_MAX     = 20,
  parameter int SHUT_PERIODS = 5,
  parameter int SHUT_LEAD    = 10,
  parameter int SEP_PERIODS  = 10,
  parameter int DLY_W        = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              stop,
  input  logic [DIV_W-1:0]  divStep,
  input  logic [LEN_W-1:0]  lineLen,
  input  logic [GATE_W-1:0] gateWidth,
  input  logic              shutEn,
  input  logic [LEN_W-1:0]  shutOffset,
  input  logic [DLY_W-1:0]  sampleDelay,
  input  logic              gainHigh,
  output logic              pixClk,
  output logic              readGate,
  output logic              shutter,
  output logic              gainSel,
  output logic              sampleValid,
  output logic [11:0]       pixIndex,
  output logic [1:0]        pixClass,
  output logic              lineStart,
  output logic              lineDone
);

  lccdStrobe_t strobe;

  lccdControl #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX),
    .LEN_W(LEN_W), .MIN_LINE(MIN_LINE),
    .GATE_W(GATE_W), .GATE_MIN(GATE_MIN), .GATE_MAX(GATE_MAX),
    .SHUT_PERIODS(SHUT_PERIODS), .SHUT_LEAD(SHUT_LEAD),
    .SEP_PERIODS(SEP_PERIODS), .DLY_W(DLY_W)
  ) i_control (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop),
    .divStep(divStep), .lineLen(lineLen), .gateWidth(gateWidth),
    .shutEn(shutEn), .shutOffset(shutOffset), .sampleDelay(sampleDelay),
    .strobe(strobe)
  );

  lccdDatapath i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pixClk(pixClk), .readGate(readGate), .shutter(shutter),
    .sampleValid(sampleValid), .pixIndex(pixIndex), .pixClass(pixClass),
    .lineStart(lineStart), .lineDone(lineDone)
  );

  // R9: gain request goes straight to the sensor pin
  assign gainSel = gainHigh;

endmodule

// File: tb/test_lccdTimingTop.sv
module test_lccdTimingTop;

  localparam int LEAD  = 1;
  localparam int SHUTP = 5;

  typedef struct packed {
    int div; int len; int gw; int shEn; int sh; int dly; int gain;
    int expD; int expL; int expG; int expSh; int expDly;
  } vec_t;

  // inputs ... expected clamped values
  localparam vec_t VECS [4] = '{
    '{1, 3100, 10, 1,   40,  3, 0,   1, 3100, 10,   40,  3},
    '{2, 2000,  3, 1,    5, 20, 1,   2, 3100,  6,   17, 15},
    '{0, 3120, 25, 1, 3200,  2, 0,   1, 3120, 20, 3104,  2},
    '{1, 3100, 10, 0,   40,  5, 1,   1, 3100, 10,   40,  5}
  };

  logic clk = 0, rstN = 0, start = 0, stop = 0, shutEn = 0, gainHigh = 0;
  logic [5:0]  divStep = 0;
  logic [12:0] lineLen = 0, shutOffset = 0;
  logic [4:0]  gateWidth = 0;
  logic [8:0]  sampleDelay = 0;
  logic pixClk, readGate, shutter, gainSel, sampleValid, lineStart, lineDone;
  logic [11:0] pixIndex;
  logic [1:0]  pixClass;

  always #10 clk = ~clk;

  lccdTimingTop #(.DIV_MIN(1), .SHUT_LEAD(LEAD), .SHUT_PERIODS(SHUTP)) i_lccdTimingTop (
    .clk(clk), .rstN(rstN), .start(start), .stop(stop), .divStep(divStep),
    .lineLen(lineLen), .gateWidth(gateWidth), .shutEn(shutEn),
    .shutOffset(shutOffset), .sampleDelay(sampleDelay), .gainHigh(gainHigh),
    .pixClk(pixClk), .readGate(readGate), .shutter(shutter), .gainSel(gainSel),
    .sampleValid(sampleValid), .pixIndex(pixIndex), .pixClass(pixClass),
    .lineStart(lineStart), .lineDone(lineDone)
  );

  int nChecks = 0, nErrors = 0;

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor state, sampled on the falling edge
  int tick = 0, starts, t0, lastRise, perMeas, hiMeas, gRise, gFall, sRise, sFall;
  int nSamp, nOb, nEff, nDum, firstOb, firstEff, firstSampT, lastIdx, lastSampT;
  int doneT, doneCnt, seqErr, overlap;
  bit prevPix = 0, prevGate = 0, prevShut = 0;

  task automatic clearMon();
    starts = 0; t0 = -1; lastRise = -1; perMeas = -1; hiMeas = -1;
    gRise = -1; gFall = -1; sRise = -1; sFall = -1;
    nSamp = 0; nOb = 0; nEff = 0; nDum = 0; firstOb = -1; firstEff = -1;
    firstSampT = -1; lastIdx = -1; lastSampT = -1;
    doneT = -1; doneCnt = 0; seqErr = 0; overlap = 0;
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      if (lineStart) begin
        starts++;
        if (starts == 1) t0 = tick;
      end
      if (starts == 1) begin
        if (pixClk && !prevPix) begin
          if (lastRise >= 0 && perMeas < 0) perMeas = tick - lastRise;
          lastRise = tick;
        end
        if (!pixClk && prevPix && hiMeas < 0) hiMeas = tick - lastRise;
        if (readGate && !prevGate && gRise < 0) gRise = tick;
        if (!readGate && prevGate && gFall < 0) gFall = tick;
        if (shutter && !prevShut && sRise < 0) sRise = tick;
        if (!shutter && prevShut && sFall < 0) sFall = tick;
        if (readGate && shutter) overlap = 1;
        if (sampleValid) begin
          if (int'(pixIndex) != nSamp) seqErr++;
          if (nSamp == 0) firstSampT = tick;
          nSamp++;
          case (pixClass)
            2'd1: begin nOb++; if (firstOb < 0) firstOb = int'(pixIndex); end
            2'd2: begin nEff++; if (firstEff < 0) firstEff = int'(pixIndex); end
            default: nDum++;
          endcase
          lastIdx = int'(pixIndex);
          lastSampT = tick;
        end
        if (lineDone) begin doneCnt++; doneT = tick; end
      end
    end
    prevPix = pixClk; prevGate = readGate; prevShut = shutter;
    tick++;
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    clearMon();
    repeat (5) @(posedge clk);
    #2;
    // R11: reset state
    check("R11 pixClk", int'(pixClk), 0);
    check("R11 readGate", int'(readGate), 0);
    check("R11 shutter", int'(shutter), 0);
    check("R11 sampleValid", int'(sampleValid), 0);
    check("R11 lineStart", int'(lineStart), 0);
    check("R11 lineDone", int'(lineDone), 0);
    rstN = 1;
    repeat (3) @(posedge clk);
    #2;
    check("R10 idle pixClk", int'(pixClk), 0);

    for (int k = 0; k < 4; k++) begin
      vec_t v;
      int p;
      v = VECS[k];
      p = 8 * v.expD;
      clearMon();
      divStep = 6'(v.div); lineLen = 13'(v.len); gateWidth = 5'(v.gw);
      shutEn = v.shEn[0]; shutOffset = 13'(v.sh); sampleDelay = 9'(v.dly);
      gainHigh = v.gain[0];
      #1;
      check("R9 gainSel", int'(gainSel), v.gain);
      @(posedge clk); #2 start = 1;
      @(posedge clk); #2 start = 0;
      repeat (10) @(posedge clk);
      #2 stop = 1;
      @(posedge clk); #2 stop = 0;
      repeat (v.expL * p + 100) @(posedge clk);
      #2;
      // R1 divider
      check("R1 pixel period", perMeas, p);
      check("R1 pixel high time", hiMeas, 4 * v.expD);
      // R2 line length
      check("R2 last pixel rise", lastRise - t0, (v.expL - 1) * p);
      // R3 readout gate
      check("R3 gate rise phase", gRise - t0, 6 * v.expD);
      check("R3 gate width", gFall - gRise, v.expG * p);
      // R4 element sequence
      check("R4 sample count", nSamp, 3066);
      check("R4 index order errors", seqErr, 0);
      check("R4 last index", lastIdx, 3065);
      // R6 sample delay
      check("R6 first sample time", firstSampT - t0, (v.expG + 1) * p + v.expDly);
      check("R6 last sample time", lastSampT - t0, (v.expG + 3066) * p + v.expDly);
      // R5 classes
      check("R5 black count", nOb, 30);
      check("R5 effective count", nEff, 3000);
      check("R5 dummy count", nDum, 36);
      check("R5 first black index", firstOb, 24);
      check("R5 first effective index", firstEff, 56);
      // R7 shutter
      if (v.shEn != 0) begin
        check("R7 shutter rise", sRise - t0, v.expSh * p + LEAD);
        check("R7 shutter width", sFall - sRise, SHUTP * p);
      end else begin
        check("R7 shutter disabled", sRise, -1);
      end
      check("R7 gate/shutter overlap", overlap, 0);
      // R8 line done (coincides with last sample when delay is at its ceiling)
      check("R8 done count", doneCnt, 1);
      check("R8 done time", doneT - t0, (v.expG + 3067) * p - 1);
      // R10 stop at boundary
      check("R10 single line", starts, 1);
      check("R10 idle pixClk", int'(pixClk), 0);
      check("R10 idle readGate", int'(readGate), 0);
    end

    // R9: gain pin follows its input while idle
    gainHigh = 1; #1;
    check("R9 gainSel high", int'(gainSel), 1);
    gainHigh = 0; #1;
    check("R9 gainSel low", int'(gainSel), 0);

    finishRun();
  end

endmodule